// File: doc/BRIEF.md
# Register Write-Protection Controller

This block keeps a small group of protected control bits behind a write-protection latch. Software reaches it through one control register on a simple read/write port. Two bits of that register run the latch. The guard-set bit reads 1 while protection is on. The guard-clear bit always reads as the inverse of the guard-set bit.

Writing 1 to guard-set turns protection on. Protection comes off only through a two-step sequence. First a read of the control register must return guard-set as 1. The very next access must then write 1 to guard-clear. Any access in between cancels the armed sequence, while idle cycles do not.

The latch drives a write-permit output. That output gates writes to the protected fields. Here it gates the module-enable bit, which picks the restricted legacy register set (0) or full register access (1).

Top module: `wp_ctrl`

## Requirements
- R1: After reset deassertion, protection is on: wr_permit_o is 0, mod_en_o is 0, and a read of the control register returns 0x02.
- R2: A read of the control register returns module-enable in bit 0, guard-set in bit 1, and guard-clear in bit 2; bit 2 is always the inverse of bit 1 and the upper bits read 0.
- R3: A write to the control register with bit 1 set turns protection on from the next cycle.
- R4: A write with bit 2 set and bit 1 clear removes protection from the next cycle, provided the access just before it was a read of the control register that returned bit 1 as 1.
- R5: A write of bit 2 as 1 that does not directly follow a qualifying read leaves protection on.
- R6: Any access to any address between the qualifying read and the unlock write cancels the armed unlock; cycles with req_i low do not cancel it.
- R7: Writing 0 to bit 1 or to bit 2 does not change the protection state.
- R8: Module-enable takes bit 0 of a control-register write only when wr_permit_o was 1 before that write; otherwise it keeps its value. This holds even when the same write changes the protection state.
- R9: When one write sets both bit 1 and bit 2, protection ends up on, whether or not an unlock was armed.
- R10: Writes to addresses other than CTRL_ADDR change nothing, and reads of those addresses return 0.
- R11: wr_permit_o always equals the guard-clear bit, which is the inverse of guard-set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid in the cycle of a read, 0 otherwise |
| wr_permit_o | output | 1 | High while protected fields may be written |
| mod_en_o | output | 1 | Protected module-enable bit |

## Verification
On every cycle, the assertions check three things. wr_permit_o must track the inverse of the latch. The read data must keep guard-clear opposite to guard-set. Module-enable may change only while writes are permitted. The assertions also check that protection comes off only with an armed sequence and that a lock write always takes effect. The bench scenarios are needed to show the ordering rules. These are the cancelling of the armed sequence by a stray access, the survival of that sequence across idle cycles, the lock winning over a combined write, and the return to the protected state after a reset taken mid-run.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int unsigned MOD_EN_BIT = 0;
  localparam int unsigned GSET_BIT   = 1;
  localparam int unsigned GCLR_BIT   = 2;

  typedef struct packed {
    logic any;
    logic rd_hit;
    logic wr_hit;
    logic set_req;
    logic clr_req;
    logic mod_wd;
  } acc_t;
endpackage

// File: rtl/wp_access_dec.sv
module wp_access_dec
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output acc_t              acc_o
);
  logic hit;
  assign hit = req_i && (addr_i == CTRL_ADDR);

  always_comb begin
    acc_o         = '0;
    acc_o.any     = req_i;
    acc_o.rd_hit  = hit && !we_i;
    acc_o.wr_hit  = hit && we_i;
    acc_o.set_req = acc_o.wr_hit && wdata_i[GSET_BIT];
    acc_o.clr_req = acc_o.wr_hit && wdata_i[GCLR_BIT];
    acc_o.mod_wd  = wdata_i[MOD_EN_BIT];
  end
endmodule

// File: rtl/wp_arm.sv
module wp_arm
  import wp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  acc_t acc_i,
  input  logic locked_i,
  output logic arm_o
);
  // every access re-evaluates; only a read seeing the lock set arms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        arm_o <= 1'b0;
    else if (acc_i.any) arm_o <= acc_i.rd_hit && locked_i;
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  acc_t acc_i,
  input  logic arm_i,
  output logic locked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     locked_o <= 1'b1;
    else if (acc_i.set_req)          locked_o <= 1'b1; // lock wins
    else if (acc_i.clr_req && arm_i) locked_o <= 1'b0;
  end
endmodule

// File: rtl/wp_prot_field.sv
module wp_prot_field #(
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             permit_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               q_o <= RST_VAL;
    else if (we_i && permit_i) q_o <= d_i;
  end
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wr_permit_o,
  output logic              mod_en_o
);
  acc_t acc;
  logic arm_q;
  logic locked_q;
  logic [DATA_W-1:0] ctrl_val;

  wp_access_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) i_dec (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .acc_o(acc)
  );

  wp_arm i_arm (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .locked_i(locked_q), .arm_o(arm_q)
  );

  wp_guard i_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .arm_i(arm_q), .locked_o(locked_q)
  );

  assign wr_permit_o = !locked_q;

  wp_prot_field #(.WIDTH(1), .RST_VAL(1'b0)) i_mod_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(acc.wr_hit), .permit_i(wr_permit_o),
    .d_i(acc.mod_wd), .q_o(mod_en_o)
  );

  always_comb begin
    ctrl_val             = '0;
    ctrl_val[MOD_EN_BIT] = mod_en_o;
    ctrl_val[GSET_BIT]   = locked_q;
    ctrl_val[GCLR_BIT]   = wr_permit_o;
  end

  assign rdata_o = acc.rd_hit ? ctrl_val : '0;
endmodule

// File: rtl/wp_ctrl_chk.sv
module wp_ctrl_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              wr_permit_o,
  input logic              mod_en_o,
  input logic              locked_q,
  input logic              arm_q
);
  logic rd_ctrl, wr_ctrl;
  assign rd_ctrl = req_i && !we_i && addr_i == CTRL_ADDR;
  assign wr_ctrl = req_i && we_i && addr_i == CTRL_ADDR;

  // R11
  permit_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_permit_o == !locked_q);

  // R2
  rd_inverse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ctrl |-> rdata_o[2] == !rdata_o[1]);

  // R8
  mod_guarded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mod_en_o) |-> $past(wr_permit_o));

  // R4
  unlock_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_permit_o) |-> $past(arm_q) && $past(wr_ctrl));

  // R3
  lock_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl && wdata_i[1] |=> !wr_permit_o);
endmodule

bind wp_ctrl wp_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .wr_permit_o(wr_permit_o),
  .mod_en_o(mod_en_o), .locked_q(locked_q), .arm_q(arm_q)
);

// File: tb/test_wp_ctrl.sv
module test_wp_ctrl;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 8;
  localparam logic [3:0] CA = 4'h3;
  localparam logic [3:0] OA = 4'h5;

  logic clk_i = 1'b0, rst_ni = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic wr_permit_o, mod_en_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  wp_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CA)) i_wp_ctrl (.*);

  // {req, we, addr, wdata, exp_rdata, exp_permit_after, exp_mod_after}
  localparam int NV = 26;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1,1'b1,CA,8'h01, 8'h00,1'b0,1'b0},  // 0 R8 locked write ignored
    {1'b1,1'b1,CA,8'h04, 8'h00,1'b0,1'b0},  // 1 R5 no read before
    {1'b1,1'b0,CA,8'h00, 8'h02,1'b0,1'b0},  // 2 R2 read arms
    {1'b1,1'b1,CA,8'h04, 8'h00,1'b1,1'b0},  // 3 R4 unlock
    {1'b1,1'b0,CA,8'h00, 8'h04,1'b1,1'b0},  // 4 R2
    {1'b1,1'b1,CA,8'h01, 8'h00,1'b1,1'b1},  // 5 R8 R7
    {1'b1,1'b0,CA,8'h00, 8'h05,1'b1,1'b1},  // 6 R2
    {1'b1,1'b1,CA,8'h00, 8'h00,1'b1,1'b0},  // 7 R8 R7
    {1'b1,1'b1,CA,8'h01, 8'h00,1'b1,1'b1},  // 8 R8
    {1'b1,1'b1,OA,8'h02, 8'h00,1'b1,1'b1},  // 9 R10 write elsewhere
    {1'b1,1'b0,OA,8'h00, 8'h00,1'b1,1'b1},  // 10 R10 read elsewhere
    {1'b1,1'b1,CA,8'h03, 8'h00,1'b0,1'b1},  // 11 R3 lock
    {1'b1,1'b0,CA,8'h00, 8'h03,1'b0,1'b1},  // 12 R2
    {1'b1,1'b1,CA,8'h00, 8'h00,1'b0,1'b1},  // 13 R8 R7
    {1'b1,1'b0,CA,8'h00, 8'h03,1'b0,1'b1},  // 14 arm
    {1'b1,1'b0,OA,8'h00, 8'h00,1'b0,1'b1},  // 15 R6 cancel
    {1'b1,1'b1,CA,8'h04, 8'h00,1'b0,1'b1},  // 16 R6 no unlock
    {1'b1,1'b0,CA,8'h00, 8'h03,1'b0,1'b1},  // 17 arm
    {1'b0,1'b0,CA,8'h00, 8'h00,1'b0,1'b1},  // 18 R6 idle keeps arm
    {1'b1,1'b1,CA,8'h04, 8'h00,1'b1,1'b1},  // 19 R4 R8 unlock, mod kept
    {1'b1,1'b0,CA,8'h00, 8'h05,1'b1,1'b1},  // 20
    {1'b1,1'b1,CA,8'h06, 8'h00,1'b0,1'b0},  // 21 R9 both set, lock
    {1'b1,1'b0,CA,8'h00, 8'h02,1'b0,1'b0},  // 22 arm
    {1'b1,1'b1,CA,8'h06, 8'h00,1'b0,1'b0},  // 23 R9 armed, lock wins
    {1'b1,1'b0,CA,8'h00, 8'h02,1'b0,1'b0},  // 24 arm
    {1'b1,1'b1,CA,8'h00, 8'h00,1'b0,1'b0}   // 25 R7 zero write
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic rq, input logic w, input logic [3:0] a, input logic [7:0] d);
    req_i = rq; we_i = w; addr_i = a; wdata_i = d;
  endtask

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 permit", {7'b0, wr_permit_o}, 8'h00);
    chk("R1 mod_en", {7'b0, mod_en_o}, 8'h00);
    access(1, 0, CA, 0); #1;
    chk("R1 rdata", rdata_o, 8'h02);
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][23], VEC[i][22], VEC[i][21:18], VEC[i][17:10]);
      #1;
      chk($sformatf("R2/R10 rdata v%0d", i), rdata_o, VEC[i][9:2]);
      @(negedge clk_i);
      chk($sformatf("R11 permit v%0d", i), {7'b0, wr_permit_o}, {7'b0, VEC[i][1]});
      chk($sformatf("R8 mod_en v%0d", i), {7'b0, mod_en_o}, {7'b0, VEC[i][0]});
    end

    // unlock, set mod_en, then reset mid-run -> R1
    access(1, 0, CA, 0); @(negedge clk_i);
    access(1, 1, CA, 8'h04); @(negedge clk_i);
    access(1, 1, CA, 8'h01); @(negedge clk_i);
    access(0, 0, CA, 0);
    chk("R4 unlocked before reset", {7'b0, wr_permit_o}, 8'h01);
    rst_ni = 1'b0; #1;
    chk("R1 permit in reset", {7'b0, wr_permit_o}, 8'h00);
    chk("R1 mod_en in reset", {7'b0, mod_en_o}, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1; @(negedge clk_i);
    // R5 reset clears arm: write clear without read
    access(1, 1, CA, 8'h04); @(negedge clk_i);
    access(0, 0, CA, 0);
    chk("R5 no unlock after reset", {7'b0, wr_permit_o}, 8'h00);
    // R6 write elsewhere also cancels arm
    access(1, 0, CA, 0); @(negedge clk_i);
    access(1, 1, OA, 8'h04); @(negedge clk_i);
    access(1, 1, CA, 8'h04); @(negedge clk_i);
    access(0, 0, CA, 0);
    chk("R6 write elsewhere cancels", {7'b0, wr_permit_o}, 8'h00);
    // R4 two idle cycles between read and unlock still work
    access(1, 0, CA, 0); @(negedge clk_i);
    access(0, 0, CA, 0); @(negedge clk_i); @(negedge clk_i);
    access(1, 1, CA, 8'h05); @(negedge clk_i);
    access(0, 0, CA, 0);
    chk("R4 unlock after idles", {7'b0, wr_permit_o}, 8'h01);
    chk("R8 unlock write leaves mod_en", {7'b0, mod_en_o}, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule